// File: doc/BRIEF.md
# Disk Controller Threshold Data FIFO

This block sits between a host bus and the byte side of a floppy-style disk data path. In the command and result phases it acts as a one-byte data register, and the host hands over one parameter or status byte at a time. A ready flag and a direction flag pace each exchange. In the execution phase it can hold up to `DEPTH` bytes. It raises a service request for the host or DMA engine according to the fill level, the transfer direction and a programmable threshold.

The disk side is modelled as a byte strobe, one pulse per byte period of the chosen data rate. The threshold sets the worst-case host latency, which is the threshold times the byte period minus 1.5 µs. For example, a threshold of 8 at 1 Mbps allows 62.5 µs.

An overrun on a read, or an underrun on a write, stops the transfer and sets a sticky flag for the result phase. After a write underrun the block still finishes the sector. It emits zero bytes and then a two-byte CRC. After a read overrun the host drains the bytes already held.

Top module: `disk_data_fifo`

## Requirements
- R1: After reset the buffered mode is off, the threshold field is 0, both error flags are 0, the store is empty, `svc_req` is 0 and `rqm` is 1.
- R2: `cfg_wr` loads `cfg_fifo_en` and `cfg_thresh` only while `phase` is 2'b00 (command). In any other phase it has no effect. The effective threshold T is 1 when the field is 0 and equals the field otherwise.
- R3: Phase encoding is 2'b00 command, 2'b01 execution and 2'b10 result. In command and result phases the store holds one byte, and a push into an occupied register is dropped. In the command phase `host_wr` pushes and `dec_take` pops. In the result phase `dec_give` pushes and `host_rd` pops. `dio` is 1 in the result phase, or in the execution phase with `dir_read`=1. Outside the execution phase, `rqm` is the empty flag when `dio`=0 and the non-empty flag when `dio`=1.
- R4: Entering the execution phase from any other phase empties the store, so no stale byte reaches either side.
- R5: In buffered mode on a write, `svc_req` is 1 while the level is at most T, which means the free space is at least DEPTH−T.
- R6: In buffered mode on a read, `svc_req` is 1 while the level is at least DEPTH−T.
- R7: With buffered mode off, the execution phase also holds a single byte. `svc_req` is then level==1 for a read and level==0 for a write.
- R8: Bytes leave in the order they entered. A host write into a full store is dropped.
- R9: A disk strobe on a read while the store is full sets `ovr_flag`. Every later disk byte is refused. `svc_req` stays 1 until the host has read every held byte.
- R10: A disk strobe on a write while the store is empty sets `und_flag`. From then on, host writes are dropped, `svc_req` is 0, and the sector's remaining data slots carry 8'h00.
- R11: On a write, the `SECTOR_BYTES` data slots are followed by two strobes that carry the CRC-16 (polynomial 0x1021, preset 0xFFFF, MSB-first bit order) over all data and pad bytes, high byte first. Later strobes leave `disk_wdata` unchanged. Once the data slots are used up, `svc_req` is 0.
- R12: Both error flags stay set until a `host_rd` in the result phase, or the next entry into the execution phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 2 | Controller phase: 0 command, 1 execution, 2 result |
| dir_read | input | 1 | 1 = disk-to-host transfer in the execution phase |
| cfg_wr | input | 1 | Configure strobe |
| cfg_fifo_en | input | 1 | Buffered mode enable loaded by `cfg_wr` |
| cfg_thresh | input | 4 | Threshold field loaded by `cfg_wr` |
| host_wr | input | 1 | Host writes one byte |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host reads one byte |
| host_rdata | output | 8 | Oldest held byte |
| dec_take | input | 1 | Command decoder consumes the parameter byte |
| dec_give | input | 1 | Command decoder offers a result byte |
| dec_byte | input | 8 | Result byte from the decoder |
| disk_strobe | input | 1 | One pulse per disk byte period |
| disk_rdata | input | 8 | Byte from the disk on a read |
| disk_wdata | output | 8 | Byte sent to the disk on a write, updated at each strobe |
| svc_req | output | 1 | Host/DMA service request |
| rqm | output | 1 | Ready for the next host transfer |
| dio | output | 1 | Direction flag, 1 = toward the host |
| ovr_flag | output | 1 | Sticky read overrun |
| und_flag | output | 1 | Sticky write underrun |

## Verification
The assertions take for granted that `phase` changes only between transfers, with no strobe or host access in the cycle it enters execution. They also assume `dir_read` stays constant through an execution phase, and that the host drains a read before moving to the result phase. Under those assumptions the single-byte rule and the flag latching hold cycle by cycle. The directed tests pulse every strobe for one cycle, separated by idle cycles. Each test changes phase alone and always passes through the command phase between executions. Reads are drained completely before the result phase is entered.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2,
    PH_IDLE   = 2'd3
  } phase_t;

  // One byte into a CRC-16, polynomial 0x1021, MSB first
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic int eff_thr(input logic [3:0] f);
    return (f == 4'd0) ? 1 : int'(f);
  endfunction

  // read side: enough bytes are waiting
  function automatic logic read_req(input int lvl, input int depth, input int thr);
    return (lvl + thr) >= depth;
  endfunction

  // write side: enough free space
  function automatic logic write_req(input int lvl, input int thr);
    return lvl <= thr;
  endfunction

endpackage

// File: rtl/dfifo_mem.sv
module dfifo_mem #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level
);

  logic [W-1:0]  store_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign rdata = store_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push && !flush) store_q[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else begin
      if (push) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && !pop && level == LW'(DEPTH)));
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && level == '0));

endmodule

// File: rtl/dfifo_disk.sv
module dfifo_disk
  import dfifo_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int CW = $clog2(SECTOR_BYTES + 3)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       step,
  input  logic       is_write,
  input  logic [7:0] byte_in,
  output logic       data_slot,
  output logic       done,
  output logic [7:0] wbyte
);

  logic [CW-1:0] cnt_q;
  logic [15:0]   crc_q;

  assign data_slot = cnt_q < CW'(SECTOR_BYTES);
  assign done      = cnt_q >= CW'(SECTOR_BYTES + 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= 16'hFFFF;
      wbyte <= 8'h00;
    end else if (flush) begin
      cnt_q <= '0;
      crc_q <= 16'hFFFF;
      wbyte <= 8'h00;
    end else if (step && !done) begin
      cnt_q <= cnt_q + CW'(1);
      if (data_slot) begin
        crc_q <= crc_step(crc_q, byte_in);
        if (is_write) wbyte <= byte_in;
      end else if (is_write) begin
        wbyte <= (cnt_q == CW'(SECTOR_BYTES)) ? crc_q[15:8] : crc_q[7:0];
      end
    end
  end

  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SECTOR_BYTES + 2));
  assert_crc_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flush) |=> $stable(wbyte));

endmodule

// File: rtl/disk_data_fifo.sv
module disk_data_fifo
  import dfifo_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int SECTOR_BYTES = 512,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase,
  input  logic       dir_read,
  input  logic       cfg_wr,
  input  logic       cfg_fifo_en,
  input  logic [3:0] cfg_thresh,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic       dec_take,
  input  logic       dec_give,
  input  logic [7:0] dec_byte,
  input  logic       disk_strobe,
  input  logic [7:0] disk_rdata,
  output logic [7:0] disk_wdata,
  output logic       svc_req,
  output logic       rqm,
  output logic       dio,
  output logic       ovr_flag,
  output logic       und_flag
);

  phase_t ph;
  logic fifo_en_q, prev_exec_q;
  logic [3:0] thr_q;
  logic in_cmd, in_exec, in_res, flush;
  logic [LW-1:0] level;
  logic [7:0] head, push_data, step_byte;
  logic empty, at_cap, data_slot, sector_done;
  logic push, pop, disk_step, rd_stop;
  logic disk_take, ovr_ev, rd_push, wr_step, und_ev, wr_pop;
  logic host_push_x, host_pop_x;
  int   thr;

  assign ph      = phase_t'(phase);
  assign in_cmd  = (ph == PH_CMD);
  assign in_exec = (ph == PH_EXEC);
  assign in_res  = (ph == PH_RESULT);
  assign flush   = in_exec && !prev_exec_q;
  assign thr     = eff_thr(thr_q);

  assign empty  = (level == '0);
  assign at_cap = (in_exec && fifo_en_q) ? (level == LW'(DEPTH)) : !empty;

  // read direction: disk fills, host drains
  assign rd_stop   = ovr_flag || !data_slot;
  assign disk_take = in_exec && dir_read && disk_strobe && !rd_stop && !flush;
  assign ovr_ev    = disk_take && at_cap;
  assign rd_push   = disk_take && !at_cap;
  assign host_pop_x = in_exec && dir_read && host_rd && !empty && !flush;

  // write direction: host fills, disk drains
  assign wr_step     = in_exec && !dir_read && disk_strobe && !sector_done && !flush;
  assign und_ev      = wr_step && data_slot && empty && !und_flag;
  assign wr_pop      = wr_step && data_slot && !empty && !und_flag;
  assign host_push_x = in_exec && !dir_read && host_wr && !und_flag && data_slot
                       && !at_cap && !flush;

  assign push = rd_push || host_push_x
             || (in_cmd && host_wr && empty)
             || (in_res && dec_give && empty);
  assign pop  = wr_pop || host_pop_x
             || (in_cmd && dec_take && !empty)
             || (in_res && host_rd && !empty);

  assign push_data = (in_exec && dir_read) ? disk_rdata
                   : in_res ? dec_byte : host_wdata;
  assign disk_step = rd_push || wr_step;
  assign step_byte = dir_read ? disk_rdata : ((und_flag || empty) ? 8'h00 : head);

  dfifo_mem #(.DEPTH(DEPTH), .W(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(push_data), .rdata(head), .level(level)
  );

  dfifo_disk #(.SECTOR_BYTES(SECTOR_BYTES)) u_disk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .step(disk_step),
    .is_write(!dir_read), .byte_in(step_byte), .data_slot(data_slot),
    .done(sector_done), .wbyte(disk_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q   <= 1'b0;
      thr_q       <= 4'd0;
      prev_exec_q <= 1'b0;
      ovr_flag    <= 1'b0;
      und_flag    <= 1'b0;
    end else begin
      prev_exec_q <= in_exec;
      if (cfg_wr && in_cmd) begin
        fifo_en_q <= cfg_fifo_en;
        thr_q     <= cfg_thresh;
      end
      if (flush || (in_res && host_rd)) begin
        ovr_flag <= 1'b0;
        und_flag <= 1'b0;
      end else begin
        if (ovr_ev) ovr_flag <= 1'b1;
        if (und_ev) und_flag <= 1'b1;
      end
    end
  end

  always_comb begin
    svc_req = 1'b0;
    if (in_exec) begin
      if (dir_read)
        svc_req = rd_stop ? !empty
                : fifo_en_q ? read_req(int'(level), DEPTH, thr) : !empty;
      else if (!und_flag && data_slot)
        svc_req = fifo_en_q ? write_req(int'(level), thr) : empty;
    end
  end

  assign host_rdata = head;
  assign dio = in_res || (in_exec && dir_read);
  assign rqm = in_exec ? svc_req : (dio ? !empty : empty);

  assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
  assert_ovr_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> ovr_flag);
  assert_und_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    und_ev |=> und_flag);
  assert_req_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> in_exec);
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cmd |=> ($stable(fifo_en_q) && $stable(thr_q)));
  assert_und_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (und_flag && in_exec && !dir_read) |-> !svc_req);

endmodule

// File: tb/tb_disk_data_fifo.sv
module tb_disk_data_fifo;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 16;
  localparam int SECTOR = 20;

  logic clk = 0, rst_n = 0;
  logic [1:0] phase = 2'd0;
  logic dir_read = 0, cfg_wr = 0, cfg_fifo_en = 0;
  logic [3:0] cfg_thresh = 0;
  logic host_wr = 0, host_rd = 0, dec_take = 0, dec_give = 0, disk_strobe = 0;
  logic [7:0] host_wdata = 0, dec_byte = 0, disk_rdata = 0;
  logic [7:0] host_rdata, disk_wdata;
  logic svc_req, rqm, dio, ovr_flag, und_flag;
  int ntot = 0, nfail = 0;

  disk_data_fifo #(.DEPTH(DEPTH), .SECTOR_BYTES(SECTOR)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    ntot++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input string rq, input int act, input int exp);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic set_phase(input logic [1:0] p); phase = p; cyc(); endtask
  task automatic cfg(input logic en, input logic [3:0] t);
    cfg_wr = 1; cfg_fifo_en = en; cfg_thresh = t; cyc(); cfg_wr = 0;
  endtask
  task automatic hwrite(input logic [7:0] b); host_wr = 1; host_wdata = b; cyc(); host_wr = 0; endtask
  task automatic hread(); host_rd = 1; cyc(); host_rd = 0; endtask
  task automatic strobe(input logic [7:0] b); disk_strobe = 1; disk_rdata = b; cyc(); disk_strobe = 0; endtask

  task automatic t_reset();
    chk("R1 svc_req", int'(svc_req), 0);
    chk("R1 rqm", int'(rqm), 1);
    chk("R1 dio", int'(dio), 0);
    chk("R1 flags", int'({ovr_flag, und_flag}), 0);
  endtask

  task automatic t_single_reg();
    set_phase(2'd0);
    hwrite(8'hA5);
    chk("R3 cmd rqm after write", int'(rqm), 0);
    hwrite(8'h3C);
    chk("R3 second write dropped", int'(host_rdata), 'hA5);
    dec_take = 1; cyc(); dec_take = 0;
    chk("R3 rqm after take", int'(rqm), 1);
    set_phase(2'd2);
    chk("R3 result dio", int'(dio), 1);
    chk("R3 result rqm empty", int'(rqm), 0);
    dec_byte = 8'h77; dec_give = 1; cyc(); dec_give = 0;
    chk("R3 result rqm", int'(rqm), 1);
    chk("R3 result byte", int'(host_rdata), 'h77);
    hread();
    chk("R3 rqm after read", int'(rqm), 0);
    set_phase(2'd0);
  endtask

  task automatic t_bypass();
    dir_read = 0;
    set_phase(2'd1);
    cfg(1'b1, 4'd15);   // ignored outside command phase
    chk("R7 write req empty", int'(svc_req), 1);
    hwrite(8'h11);
    chk("R2 cfg ignored in exec", int'(svc_req), 0);
    hwrite(8'h22);
    strobe(8'h00);
    chk("R7 byte out", int'(disk_wdata), 'h11);
    chk("R7 req again", int'(svc_req), 1);
    set_phase(2'd0);
    dir_read = 1;
    set_phase(2'd1);
    strobe(8'h5A);
    chk("R7 read req", int'(svc_req), 1);
    strobe(8'h6B);
    chk("R9 bypass overrun", int'(ovr_flag), 1);
    chk("R9 first byte kept", int'(host_rdata), 'h5A);
    hread();
    chk("R9 drained", int'(svc_req), 0);
    set_phase(2'd2);
    chk("R12 flag held", int'(ovr_flag), 1);
    hread();
    chk("R12 flag cleared", int'(ovr_flag), 0);
    set_phase(2'd0);
  endtask

  task automatic t_write_under();
    logic [7:0] d [16];
    logic [15:0] c = 16'hFFFF;
    cfg(1'b1, 4'd8);
    hwrite(8'hEE);
    dir_read = 0;
    set_phase(2'd1);
    chk("R4 flushed, write req", int'(svc_req), 1);
    for (int i = 0; i < 16; i++) begin
      d[i] = 8'(8'h10 + i * 3);
      hwrite(d[i]);
      chk("R5 write threshold", int'(svc_req), (i + 1 <= 8) ? 1 : 0);
    end
    hwrite(8'hFF);
    for (int i = 0; i < 16; i++) begin
      strobe(8'h00);
      chk("R8 order, R4 no stale", int'(disk_wdata), int'(d[i]));
      c = ref_crc(c, d[i]);
    end
    chk("R10 no flag yet", int'(und_flag), 0);
    strobe(8'h00);
    chk("R10 underrun flag", int'(und_flag), 1);
    chk("R10 req off", int'(svc_req), 0);
    hwrite(8'h99);
    for (int i = 16; i < SECTOR; i++) begin
      if (i > 16) strobe(8'h00);
      chk("R10 pad byte", int'(disk_wdata), 0);
      c = ref_crc(c, 8'h00);
    end
    strobe(8'h00);
    chk("R11 crc hi", int'(disk_wdata), int'(c[15:8]));
    strobe(8'h00);
    chk("R11 crc lo", int'(disk_wdata), int'(c[7:0]));
    strobe(8'h00);
    chk("R11 frozen", int'(disk_wdata), int'(c[7:0]));
    set_phase(2'd0);
  endtask

  task automatic t_write_full();
    logic [15:0] c = 16'hFFFF;
    cfg(1'b1, 4'd15);
    set_phase(2'd1);
    chk("R12 flag cleared on entry", int'(und_flag), 0);
    for (int i = 0; i < 16; i++) hwrite(8'(i * 7 + 1));
    for (int i = 0; i < 16; i++) begin strobe(8'h00); c = ref_crc(c, 8'(i * 7 + 1)); end
    for (int i = 16; i < SECTOR; i++) hwrite(8'(i * 7 + 1));
    for (int i = 16; i < SECTOR; i++) begin strobe(8'h00); c = ref_crc(c, 8'(i * 7 + 1)); end
    chk("R11 req off after data", int'(svc_req), 0);
    strobe(8'h00);
    chk("R11 full crc hi", int'(disk_wdata), int'(c[15:8]));
    strobe(8'h00);
    chk("R11 full crc lo", int'(disk_wdata), int'(c[7:0]));
    chk("R10 no underrun", int'(und_flag), 0);
    set_phase(2'd0);
  endtask

  task automatic t_read_over();
    cfg(1'b1, 4'd2);
    dir_read = 1;
    set_phase(2'd1);
    for (int i = 0; i < 16; i++) begin
      strobe(8'(8'hC0 + i));
      chk("R6 read threshold", int'(svc_req), (i + 1 >= 14) ? 1 : 0);
    end
    strobe(8'h01);
    chk("R9 overrun flag", int'(ovr_flag), 1);
    strobe(8'h02);
    for (int i = 0; i < 16; i++) begin
      chk("R9 drain req", int'(svc_req), 1);
      chk("R8 read order", int'(host_rdata), 8'hC0 + i);
      hread();
    end
    chk("R9 drained req off", int'(svc_req), 0);
    set_phase(2'd2);
    chk("R12 overrun held", int'(ovr_flag), 1);
    hread();
    chk("R12 overrun cleared", int'(ovr_flag), 0);
    set_phase(2'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    t_reset();
    t_single_reg();
    t_bypass();
    t_write_under();
    t_write_full();
    t_read_over();
    summary();
  end
endmodule